// File: doc/BRIEF.md
# SDRAM Special-Command Issuer

This block sits in front of the SDRAM pins of a local-bus memory controller and turns a bus access into one explicit SDRAM command. A 3-bit operation field, held in a control register outside the block, selects what a bus access does. Code 000 is normal mode, where the normal transfer path owns the access and this block stays silent. Any other code makes the next accepted access drive one command on the chip-select, row-strobe, column-strobe, write-enable, bank, address, clock-enable and byte-mask pins. The command is one of: refresh, self-refresh, mode load, precharge of one bank or of all banks, row activate, or a dummy read or write burst.

Burst length is not programmable. It follows the port width: 4 beats on a 16-bit port and 8 beats on 8-bit and 32-bit ports. The CAS latency is 2 or 3. Both values are sent to the device by the mode-load command. The block keeps one open-row bit for each bank. It refuses an activate to a bank that is already open, and a refresh while any bank is open. It also counts out a fixed guard time after the device leaves self-refresh.

Top module: `sdram_cmd_issuer`

## Requirements
- R1: After reset the pins are deselected ({cs_n,ras_n,cas_n,we_n} = 1111). Clock enable is high, the byte masks are all ones, and busy, done and err are low. With the operation field at 000, norm_ok is high.
- R2: A request sampled while busy is low and the operation field is non-zero puts its command on the pins in the next cycle, for exactly one cycle. For a non-burst command, done pulses for one cycle in the cycle after that. A request sampled while busy is high, or while the field is 000, drives no command and produces no done.
- R3: Pin codes as {cs_n,ras_n,cas_n,we_n}: activate 0011, precharge 0010, refresh and self-refresh 0001, mode load 0000, read 0101, write 0100. Deselect has cs_n = 1 and the other three at 1.
- R4: A precharge drives address bit 10 high for operation code 101 (all banks) and low for code 100 (one bank, chosen by the bank pins).
- R5: A mode load (code 011) drives address bits 2:0 = 011 for an 8-beat burst and 010 for a 4-beat burst, and bits 6:4 = the CAS latency. All other address bits and the bank pins are 0. Port code 01 (16-bit) gives 4 beats; codes 00 (8-bit), 10 (32-bit) and 11 give 8 beats. A latency field of 2 gives latency 2; every other value gives 3.
- R6: Code 111 issues a read (req_wr = 0) or a write (req_wr = 1). The column comes from the request address with bit 10 forced low, and the bank from the request. Counting the command cycle as cycle 1, done comes in cycle BL+1 for a write and CL+BL+1 for a read. The pins stay deselected in between, and the byte masks are all zero from the command cycle until done.
- R7: An activate (code 110) drives the request row and bank. An activate to a bank that is already open drives no command and raises err for one cycle in place of the command cycle; done still follows.
- R8: A refresh (code 001) issued while any bank is open is suppressed in the same way as R7. A precharge closes the banks it covers.
- R9: Self-refresh (code 010) issues the refresh code with clock enable low. Clock enable stays low and busy stays high until the operation field reads 000. Clock enable then rises at the next edge, and busy stays high for EXIT_WAIT (default 200) further cycles.
- R10: norm_ok is high exactly when the field is 000, the device is out of self-refresh and the exit guard count has run out. It goes high EXIT_WAIT cycles after the edge where clock enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all pins change on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_mode | input | 3 | Operation field from the control register |
| cfg_cas | input | 2 | CAS latency field (2 or 3) |
| cfg_port | input | 2 | Port width: 00 8-bit, 01 16-bit, 10 32-bit |
| req | input | 1 | Bus access strobe |
| req_wr | input | 1 | Bus access is a write |
| req_bank | input | BA_W | Bank of the access |
| req_addr | input | ADDR_W | Row or column of the access |
| busy | output | 1 | Command in flight, self-refresh or exit guard active |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for a refused command |
| norm_ok | output | 1 | Normal transfers permitted |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_ba | output | BA_W | SDRAM bank address |
| sd_addr | output | ADDR_W | SDRAM address, bit 10 is the precharge scope / auto-precharge bit |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_dqm | output | DQM_W | SDRAM byte masks |

## Verification
Every pin is registered once, so a command shows up one edge after the request is sampled. The bench drives on the falling edge and reads the command at the falling edge that follows the accepting edge. done is due one cycle after the command for single commands. For bursts it is due BL or CL+BL cycles after the command, and the bench counts falling edges from the command cycle and compares the count with the value it computes from the port and latency codes over the full sweep. For the self-refresh exit, the bench samples clock enable one edge after the field returns to 000. It then counts falling edges until norm_ok rises and expects exactly EXIT_WAIT.

// File: rtl/sdram_cmd_pkg.sv
// Shared types for the SDRAM special-command issuer: operation codes,
// pin-level command codes and small helpers for burst length and CAS latency.
// Assumes a 4-wire command bus {cs_n, ras_n, cas_n, we_n}.
package sdram_cmd_pkg;

    typedef enum logic [2:0] {
        OP_NORMAL  = 3'b000,
        OP_AREF    = 3'b001,
        OP_SREF    = 3'b010,
        OP_MSET    = 3'b011,
        OP_PRE_ONE = 3'b100,
        OP_PRE_ALL = 3'b101,
        OP_ACT     = 3'b110,
        OP_RW      = 3'b111
    } op_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pin_t;

    localparam pin_t PIN_DESEL = 4'b1111;
    localparam pin_t PIN_ACT   = 4'b0011;
    localparam pin_t PIN_PRE   = 4'b0010;
    localparam pin_t PIN_REF   = 4'b0001;
    localparam pin_t PIN_MRS   = 4'b0000;
    localparam pin_t PIN_READ  = 4'b0101;
    localparam pin_t PIN_WRITE = 4'b0100;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CMD   = 2'd1,
        ST_BURST = 2'd2,
        ST_DONE  = 2'd3
    } st_e;

    // Beats per burst: 4 on a 16-bit port, 8 otherwise.
    function automatic logic [3:0] beats_of(input logic [1:0] port);
        return (port == 2'b01) ? 4'd4 : 4'd8;
    endfunction

    // CAS latency: 2 when asked for, 3 for every other code.
    function automatic logic [1:0] cas_of(input logic [1:0] code);
        return (code == 2'd2) ? 2'd2 : 2'd3;
    endfunction

endpackage

// File: rtl/sdram_bank_track.sv
// Open-row tracker: one bit per bank, set by an accepted activate and cleared
// by a precharge of that bank or of all banks. Precharge wins over activate.
module sdram_bank_track #(
    parameter int BANKS = 4,
    localparam int BA_W = $clog2(BANKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_set,
    input  logic             pre_one,
    input  logic             pre_all,
    input  logic [BA_W-1:0]  bank,
    output logic [BANKS-1:0] open_mask
);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        // Purpose: keep the open/closed state of bank b.
        always_ff @(posedge clk) begin
            if (!rst_n)
                open_mask[b] <= 1'b0;
            else if (pre_all || (pre_one && bank == BA_W'(b)))
                open_mask[b] <= 1'b0;
            else if (act_set && bank == BA_W'(b))
                open_mask[b] <= 1'b1;
        end
    end

endmodule

// File: rtl/sdram_beat_ctr.sv
// Down-counter for the cycles a burst occupies after its command cycle.
// Assumes load_val >= 1; last is high in the final counted cycle.
module sdram_beat_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic             last
);

    logic [CNT_W-1:0] cnt;

    // Purpose: load the remaining cycle count, then count down while stepping.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (step && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == CNT_W'(1));

endmodule

// File: rtl/sdram_sref_ctl.sv
// Self-refresh state and exit guard. Entry drops clock enable. Exit happens
// on the first edge that sees the normal-mode code; a guard count of
// EXIT_WAIT cycles then runs before normal transfers are allowed again.
module sdram_sref_ctl #(
    parameter int EXIT_WAIT = 200,
    localparam int W_W = $clog2(EXIT_WAIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enter,
    input  logic normal_sel,
    output logic sref_on,
    output logic exit_wait,
    output logic cke
);

    logic [W_W-1:0] wait_cnt;

    // Purpose: track self-refresh residency and count down the exit guard.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sref_on  <= 1'b0;
            wait_cnt <= '0;
        end else if (enter) begin
            sref_on  <= 1'b1;
        end else if (sref_on && normal_sel) begin
            sref_on  <= 1'b0;
            wait_cnt <= W_W'(EXIT_WAIT);
        end else if (wait_cnt != '0) begin
            wait_cnt <= wait_cnt - 1'b1;
        end
    end

    assign exit_wait = (wait_cnt != '0);
    assign cke       = !sref_on;

endmodule

// File: rtl/sdram_cmd_issuer.sv
// Top of the SDRAM special-command issuer. When the operation field is
// non-zero, a bus request is turned into one SDRAM command, or into a dummy
// read/write burst, on registered pins. Assumes ADDR_W > 10 (bit 10 carries
// the precharge scope) and that the field is held stable while busy.
module sdram_cmd_issuer
    import sdram_cmd_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int BANKS     = 4,
    parameter int DQM_W     = 4,
    parameter int EXIT_WAIT = 200,
    parameter int MAX_BEATS = 8,
    parameter int MAX_CL    = 3,
    localparam int BA_W     = $clog2(BANKS),
    localparam int CNT_W    = $clog2(MAX_BEATS + MAX_CL + 1),
    localparam int A10      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_mode,
    input  logic [1:0]        cfg_cas,
    input  logic [1:0]        cfg_port,
    input  logic              req,
    input  logic              req_wr,
    input  logic [BA_W-1:0]   req_bank,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              norm_ok,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              sd_cke,
    output logic [DQM_W-1:0]  sd_dqm
);

    op_e               op;
    st_e               st;
    pin_t              pin_q, pin_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [BA_W-1:0]   ba_q, ba_d;
    logic [DQM_W-1:0]  dqm_q;
    logic              err_q, rw_q, rd_q, conflict, accept;
    logic [3:0]        bl_q;
    logic [1:0]        cl_q;
    logic [BANKS-1:0]  open_mask;
    logic              sref_on, exit_wait, burst_last;
    logic [CNT_W-1:0]  burst_len;

    assign op     = op_e'(op_mode);
    assign accept = (st == ST_IDLE) && req && !sref_on && !exit_wait
                    && (op != OP_NORMAL);

    // Purpose: decide whether the requested command breaks the bank rules.
    always_comb begin
        case (op)
            OP_ACT:  conflict = open_mask[req_bank];
            OP_AREF: conflict = |open_mask;
            default: conflict = 1'b0;
        endcase
    end

    // Purpose: build the pin code, address and bank for the requested command.
    always_comb begin
        pin_d  = PIN_DESEL;
        addr_d = '0;
        ba_d   = '0;
        case (op)
            OP_ACT: begin
                pin_d  = PIN_ACT;
                addr_d = req_addr;
                ba_d   = req_bank;
            end
            OP_PRE_ONE: begin
                pin_d  = PIN_PRE;
                ba_d   = req_bank;
            end
            OP_PRE_ALL: begin
                pin_d       = PIN_PRE;
                addr_d[A10] = 1'b1;
            end
            OP_AREF, OP_SREF: pin_d = PIN_REF;
            OP_MSET: begin
                pin_d       = PIN_MRS;
                addr_d[2:0] = (beats_of(cfg_port) == 4'd8) ? 3'b011 : 3'b010;
                addr_d[6:4] = {1'b0, cas_of(cfg_cas)};
            end
            OP_RW: begin
                pin_d       = req_wr ? PIN_WRITE : PIN_READ;
                addr_d      = req_addr;
                addr_d[A10] = 1'b0;
                ba_d        = req_bank;
            end
            default: pin_d = PIN_DESEL;
        endcase
    end

    // Purpose: sequence one command through command, burst and done cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            pin_q  <= PIN_DESEL;
            addr_q <= '0;
            ba_q   <= '0;
            dqm_q  <= '1;
            err_q  <= 1'b0;
            rw_q   <= 1'b0;
            rd_q   <= 1'b0;
            bl_q   <= 4'd8;
            cl_q   <= 2'd3;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        st     <= ST_CMD;
                        pin_q  <= conflict ? PIN_DESEL : pin_d;
                        addr_q <= conflict ? '0 : addr_d;
                        ba_q   <= conflict ? '0 : ba_d;
                        err_q  <= conflict;
                        rw_q   <= (op == OP_RW);
                        rd_q   <= (op == OP_RW) && !req_wr;
                        dqm_q  <= (op == OP_RW) ? '0 : '1;
                        bl_q   <= beats_of(cfg_port);
                        cl_q   <= cas_of(cfg_cas);
                    end
                end
                ST_CMD: begin
                    pin_q  <= PIN_DESEL;
                    addr_q <= '0;
                    ba_q   <= '0;
                    err_q  <= 1'b0;
                    st     <= rw_q ? ST_BURST : ST_DONE;
                end
                ST_BURST: begin
                    if (burst_last) begin
                        st    <= ST_DONE;
                        dqm_q <= '1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Cycles spent in the burst state after the command cycle.
    assign burst_len = rd_q ? CNT_W'(bl_q) + CNT_W'(cl_q) - CNT_W'(1)
                            : CNT_W'(bl_q) - CNT_W'(1);

    sdram_beat_ctr #(.CNT_W(CNT_W)) u_beats (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (st == ST_CMD && rw_q),
        .load_val (burst_len),
        .step     (st == ST_BURST),
        .last     (burst_last)
    );

    sdram_bank_track #(.BANKS(BANKS)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_set   (accept && op == OP_ACT && !conflict),
        .pre_one   (accept && op == OP_PRE_ONE),
        .pre_all   (accept && op == OP_PRE_ALL),
        .bank      (req_bank),
        .open_mask (open_mask)
    );

    sdram_sref_ctl #(.EXIT_WAIT(EXIT_WAIT)) u_sref (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter      (accept && op == OP_SREF),
        .normal_sel (op == OP_NORMAL),
        .sref_on    (sref_on),
        .exit_wait  (exit_wait),
        .cke        (sd_cke)
    );

    assign busy     = (st != ST_IDLE) || sref_on || exit_wait;
    assign done     = (st == ST_DONE);
    assign err      = err_q;
    assign norm_ok  = (op == OP_NORMAL) && !sref_on && !exit_wait;
    assign sd_cs_n  = pin_q.cs_n;
    assign sd_ras_n = pin_q.ras_n;
    assign sd_cas_n = pin_q.cas_n;
    assign sd_we_n  = pin_q.we_n;
    assign sd_ba    = ba_q;
    assign sd_addr  = addr_q;
    assign sd_dqm   = dqm_q;

endmodule

// File: rtl/sdram_cmd_issuer_chk.sv
// Port-level checker for the SDRAM special-command issuer, bound to the top.
module sdram_cmd_issuer_chk #(
    parameter int ADDR_W = 13,
    parameter int DQM_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_mode,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              norm_ok,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic              sd_cke,
    input logic [DQM_W-1:0]  sd_dqm
);

    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_cs_n |=> sd_cs_n);  // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R2
    AST_PRE_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && !sd_ras_n && sd_cas_n && !sd_we_n)
        |-> (sd_addr[10] == ($past(op_mode) == 3'b101)));  // R4
    AST_IDLE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sd_cs_n && sd_dqm == {DQM_W{1'b1}}));  // R6
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> sd_cs_n);  // R7
    AST_CKE_FALL_REF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_cke) |-> (!sd_cs_n && !sd_ras_n && !sd_cas_n && sd_we_n));  // R9
    AST_NORM_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        norm_ok |-> (sd_cke && !busy));  // R10

endmodule

bind sdram_cmd_issuer sdram_cmd_issuer_chk #(.ADDR_W(ADDR_W), .DQM_W(DQM_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_mode  (op_mode),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .norm_ok  (norm_ok),
    .sd_cs_n  (sd_cs_n),
    .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n),
    .sd_we_n  (sd_we_n),
    .sd_addr  (sd_addr),
    .sd_cke   (sd_cke),
    .sd_dqm   (sd_dqm)
);

// File: tb/sdram_cmd_issuer_tb.sv
module sdram_cmd_issuer_tb;

    localparam int ADDR_W = 13;
    localparam int BA_W   = 2;
    localparam int EXIT_W = 200;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        op_mode = 3'b000;
    logic [1:0]        cfg_cas = 2'd2;
    logic [1:0]        cfg_port = 2'd0;
    logic              req = 1'b0;
    logic              req_wr = 1'b0;
    logic [BA_W-1:0]   req_bank = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              busy, done, err, norm_ok;
    logic              sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke;
    logic [BA_W-1:0]   sd_ba;
    logic [ADDR_W-1:0] sd_addr;
    logic [3:0]        sd_dqm;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sdram_cmd_issuer u_dut (
        .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .cfg_cas(cfg_cas),
        .cfg_port(cfg_port), .req(req), .req_wr(req_wr), .req_bank(req_bank),
        .req_addr(req_addr), .busy(busy), .done(done), .err(err),
        .norm_ok(norm_ok), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
        .sd_addr(sd_addr), .sd_cke(sd_cke), .sd_dqm(sd_dqm)
    );

    function automatic int pins();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Present one request; returns at the falling edge of the command cycle.
    task automatic send(input logic [2:0] op, input int bank, input int addr, input bit wr);
        @(negedge clk);
        op_mode  = op;
        req_bank = BA_W'(bank);
        req_addr = ADDR_W'(addr);
        req_wr   = wr;
        req      = 1'b1;
        @(negedge clk);
        req      = 1'b0;
    endtask

    // Count cycles from the command cycle (1) to done; report stray commands and unmasked bytes.
    task automatic wait_done(output int n, output int stray, output int badmask, input bit rw);
        n = 1; stray = 0; badmask = 0;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
            if (!done && !sd_cs_n) stray++;
            if (!done && rw && sd_dqm != 4'h0) badmask++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        if (!finished) begin
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, stray, bm, bl, cl, ex;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pins", pins(), 4'hF);
        check("R1 cke", sd_cke, 1);
        check("R1 dqm", sd_dqm, 4'hF);
        check("R1 busy/done/err", {busy, done, err}, 0);
        check("R1 norm_ok", norm_ok, 1);

        // R2 normal-mode request is ignored
        send(3'b000, 1, 5, 0);
        n = 0;
        for (int i = 0; i < 4; i++) begin
            if (!sd_cs_n || done || busy) n++;
            @(negedge clk);
        end
        check("R2 normal-mode ignored", n, 0);

        // R5 mode load sweep over latency and port codes
        for (int c = 0; c < 4; c++) begin
            for (int p = 0; p < 4; p++) begin
                cfg_cas = 2'(c); cfg_port = 2'(p);
                bl = (p == 1) ? 2 : 3;
                cl = (c == 2) ? 2 : 3;
                send(3'b011, 3, 13'h1FFF, 0);
                check("R3 mode-load code", pins(), 4'h0);
                check("R5 mode word", {sd_ba, sd_addr}, (cl << 4) | bl);
                wait_done(n, stray, bm, 0);
                check("R2 done after single command", n, 2);
            end
        end

        // R4 precharge scope
        send(3'b101, 2, 13'h1FFF, 0);
        check("R3 precharge code", pins(), 4'h2);
        check("R4 precharge all A10", sd_addr[10], 1);
        wait_done(n, stray, bm, 0);
        send(3'b100, 2, 13'h1FFF, 0);
        check("R4 precharge one A10", sd_addr[10], 0);
        check("R4 precharge one bank", sd_ba, 2);
        wait_done(n, stray, bm, 0);

        // R7 activate every bank, then a repeat
        for (int b = 0; b < 4; b++) begin
            send(3'b110, b, 13'h0A5 + b, 0);
            check("R7 activate code", pins(), 4'h3);
            check("R7 activate bank/row", {sd_ba, sd_addr}, (b << ADDR_W) | (13'h0A5 + b));
            check("R7 no err", err, 0);
            wait_done(n, stray, bm, 0);
        end
        send(3'b110, 1, 13'h077, 0);
        check("R7 repeat activate suppressed", pins(), 4'hF);
        check("R7 repeat activate err", err, 1);
        wait_done(n, stray, bm, 0);
        check("R7 done after refused activate", n, 2);

        // R8 refresh while open, then after precharges
        send(3'b001, 0, 0, 0);
        check("R8 refresh refused", {err, sd_cs_n}, 2'b11);
        wait_done(n, stray, bm, 0);
        for (int b = 0; b < 4; b++) begin
            send(3'b100, b, 0, 0);
            wait_done(n, stray, bm, 0);
        end
        send(3'b001, 0, 0, 0);
        check("R8 refresh issued", {err, 4'(pins())}, 5'h01);
        wait_done(n, stray, bm, 0);
        send(3'b110, 3, 13'h10, 0);
        check("R8 bank reopens after precharge", {err, 4'(pins())}, 5'h03);
        wait_done(n, stray, bm, 0);

        // R6 burst sweep: port x latency x direction
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 4; c++) begin
                for (int w = 0; w < 2; w++) begin
                    cfg_port = 2'(p); cfg_cas = 2'(c);
                    bl = (p == 1) ? 4 : 8;
                    cl = (c == 2) ? 2 : 3;
                    ex = (w == 1) ? bl + 1 : cl + bl + 1;
                    send(3'b111, p, 13'h0555 | 13'h0400, bit'(w));
                    check("R6 burst command", pins(), (w == 1) ? 4'h4 : 4'h5);
                    check("R6 column A10 low", {sd_ba, sd_addr}, (p << ADDR_W) | 13'h0155);
                    check("R6 masks open at command", sd_dqm, 0);
                    wait_done(n, stray, bm, 1);
                    check("R6 done cycle", n, ex);
                    check("R6 quiet burst", stray + bm, 0);
                    check("R6 masks after done", sd_dqm, 4'hF);
                end
            end
        end

        // R2 request during busy is ignored
        cfg_port = 2'd0; cfg_cas = 2'd3;
        send(3'b111, 0, 0, 1'b0);
        @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        wait_done(n, stray, bm, 1);
        check("R2 busy request no command", stray, 0);
        check("R2 busy request no extra time", n, 3 + 8 + 1 - 2);
        stray = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (!sd_cs_n || done) stray++;
        end
        check("R2 busy request dropped", stray, 0);

        // R9 self-refresh entry and exit, R10 guard time
        send(3'b010, 0, 0, 0);
        check("R9 self-refresh code", pins(), 4'h1);
        check("R9 cke low", sd_cke, 0);
        wait_done(n, stray, bm, 0);
        send(3'b110, 0, 0, 0);
        check("R9 request ignored in self-refresh", {busy, sd_cke, sd_cs_n}, 3'b101);
        repeat (5) @(negedge clk);
        check("R9 cke held low", sd_cke, 0);
        check("R10 norm_ok low in self-refresh", norm_ok, 0);
        op_mode = 3'b000;
        @(negedge clk);
        check("R9 cke high after exit", sd_cke, 1);
        check("R10 guard active", {norm_ok, busy}, 2'b01);
        n = 0;
        while (!norm_ok && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check("R10 guard length", n, EXIT_W);
        check("R10 busy released", busy, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule